// File: doc/BRIEF.md
# Per-Channel Missing Start-of-Packet Repair

This block sits on a receive packet bus where beats from up to 256 channels arrive interleaved. Each beat carries a channel number, start and end markers, an error flag and payload. The block keeps one small state machine per channel that records whether a packet is open on that channel and whether that packet must end in error. Beats pass through with one register stage and keep their arrival order. The payload and the channel number are never altered.

A beat that reaches a channel with no open packet and has no start marker is repaired. The block sets the start marker on that beat and raises a one-cycle missing-start pulse alongside it. The packet then opened ends with its error flag forced high. A link-level error pulse (alignment loss, CRC error, short burst, bad control type or bad framing, all detected upstream) moves every open channel into the errored state. Each packet then in flight on any channel ends with the error flag.

Per-channel states: `CH_CLOSED` (no packet), `CH_OPEN` (clean packet in flight), `CH_OPEN_ERR` (packet in flight that must end in error). The transitions are as follows:
- *start*: a start beat without end moves any state to `CH_OPEN`.
- *single*: a start beat with end moves any state to `CH_CLOSED`.
- *repair*: a middle beat on `CH_CLOSED` moves it to `CH_OPEN_ERR`.
- *repair-single*: an end beat without start on `CH_CLOSED` leaves it in `CH_CLOSED`.
- *continue*: a middle beat keeps `CH_OPEN` or `CH_OPEN_ERR`.
- *close*: an end beat moves either open state to `CH_CLOSED`.
- *poison*: the link error moves `CH_OPEN` to `CH_OPEN_ERR`.

Top module: `msr_sop_repair`

## Requirements
- R1: One clock after a beat is presented with `in_vld` high, it appears on the outputs with `out_vld` high, and its `out_data` and `out_chan` are equal to the inputs. A cycle with `in_vld` low gives `out_vld`, `out_sop` and `msop_err` low one clock later.
- R2: A beat without start on a channel with no open packet drives `msop_err` high for exactly the one output cycle of that beat. No other beat raises it.
- R3: On such a repaired beat, `out_sop` is 1.
- R4: A packet opened by repair ends with `out_err` 1 on its end beat. A repaired beat that also carries an end marker has `out_err` 1.
- R5: A `link_err` pulse forces `out_err` to 1 on the next end beat of every channel that had a packet open. Closed channels are unaffected: their next packet, started normally, ends with `out_err` equal to `in_err`.
- R6: On a clean open packet, `out_sop` equals `in_sop` and `out_err` equals `in_err`, including on the end beat.
- R7: A start beat on a channel that is already open closes the old packet silently (no `msop_err`) and begins a clean packet. Any pending error of the old packet is dropped.
- R8: A beat with both start and end markers on a closed channel is a complete packet and leaves the channel closed. A later middle beat on it is therefore repaired.
- R9: After reset all channels are closed and all outputs are 0.
- R10: When `link_err` coincides with a beat, an end beat on an already open channel carries `out_err` 1. A packet opened by that same beat is also marked errored.
- R11: Channels are independent. A repair or an error mark on one channel does not change the markers or the error flag of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input beat valid |
| in_sop | input | 1 | Input start-of-packet marker |
| in_eop | input | 1 | Input end-of-packet marker |
| in_err | input | 1 | Input error flag |
| in_chan | input | CHAN_W (8) | Input channel number |
| in_data | input | DATA_W (64) | Input payload |
| link_err | input | 1 | One-cycle link-level error pulse |
| out_vld | output | 1 | Output beat valid |
| out_sop | output | 1 | Output start marker, repaired |
| out_eop | output | 1 | Output end marker |
| out_err | output | 1 | Output error flag, with deferred errors applied |
| out_chan | output | CHAN_W (8) | Output channel number |
| out_data | output | DATA_W (64) | Output payload |
| msop_err | output | 1 | Missing-start pulse, aligned with the repaired beat |

## Verification
The bench first sends an end-only beat to a closed channel. A design that treated it as a middle beat would leave the channel open or miss the error on that same beat. It then sends a second start to a channel with a pending repair error. A design that kept the pending bit would wrongly fail the new clean packet. A link error is made to coincide with an end beat and with a start beat. This exposes designs that apply the mark one cycle late or skip the channel written in that cycle. Two interleaved channels, one repaired and one clean, catch any state leaking across table entries.

// File: rtl/msr_pkg.sv
package msr_pkg;
    typedef enum logic [1:0] {
        CH_CLOSED   = 2'd0,
        CH_OPEN     = 2'd1,
        CH_OPEN_ERR = 2'd2
    } ch_state_e;
endpackage

// File: rtl/msr_state_table.sv
module msr_state_table
    import msr_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] rd_chan,
    output ch_state_e         rd_state,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_chan,
    input  ch_state_e         wr_state,
    input  logic              poison_all
);
    localparam int NUM_CH = 1 << CHAN_W;

    ch_state_e st_q [NUM_CH];

    // One state register per channel; the beat write wins over the global
    // poison because the written value already carries the poison.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[ch] <= CH_CLOSED;
            end else if (wr_en && (wr_chan == CHAN_W'(ch))) begin
                st_q[ch] <= wr_state;
            end else if (poison_all && (st_q[ch] == CH_OPEN)) begin
                st_q[ch] <= CH_OPEN_ERR;
            end
        end
    end

    assign rd_state = st_q[rd_chan];
endmodule

// File: rtl/msr_decide.sv
module msr_decide
    import msr_pkg::*;
(
    input  logic      in_vld,
    input  logic      in_sop,
    input  logic      in_eop,
    input  logic      in_err,
    input  logic      link_err,
    input  ch_state_e cur_state,
    output ch_state_e nxt_state,
    output logic      fix_sop,
    output logic      fix_err,
    output logic      miss
);
    ch_state_e eff_state;
    ch_state_e raw_nxt;

    // A link error in this cycle already counts for the beat of this cycle.
    always_comb begin
        if (link_err && (cur_state != CH_CLOSED)) eff_state = CH_OPEN_ERR;
        else                                      eff_state = cur_state;
    end

    always_comb begin
        raw_nxt = cur_state;
        fix_sop = in_sop;
        fix_err = in_err;
        miss    = 1'b0;
        if (in_vld) begin
            if (in_sop) begin
                raw_nxt = in_eop ? CH_CLOSED : CH_OPEN;
            end else begin
                unique case (eff_state)
                    CH_OPEN: begin
                        raw_nxt = in_eop ? CH_CLOSED : CH_OPEN;
                    end
                    CH_OPEN_ERR: begin
                        fix_err = in_err | in_eop;
                        raw_nxt = in_eop ? CH_CLOSED : CH_OPEN_ERR;
                    end
                    default: begin
                        miss    = 1'b1;
                        fix_sop = 1'b1;
                        fix_err = in_err | in_eop;
                        raw_nxt = in_eop ? CH_CLOSED : CH_OPEN_ERR;
                    end
                endcase
            end
        end
    end

    always_comb begin
        if (link_err && (raw_nxt == CH_OPEN)) nxt_state = CH_OPEN_ERR;
        else                                  nxt_state = raw_nxt;
    end
endmodule

// File: rtl/msr_out_stage.sv
module msr_out_stage #(
    parameter int DATA_W = 64,
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              d_vld,
    input  logic              d_sop,
    input  logic              d_eop,
    input  logic              d_err,
    input  logic              d_miss,
    input  logic [CHAN_W-1:0] d_chan,
    input  logic [DATA_W-1:0] d_data,
    output logic              q_vld,
    output logic              q_sop,
    output logic              q_eop,
    output logic              q_err,
    output logic              q_miss,
    output logic [CHAN_W-1:0] q_chan,
    output logic [DATA_W-1:0] q_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_vld  <= 1'b0;
            q_sop  <= 1'b0;
            q_eop  <= 1'b0;
            q_err  <= 1'b0;
            q_miss <= 1'b0;
            q_chan <= '0;
            q_data <= '0;
        end else begin
            q_vld  <= d_vld;
            q_sop  <= d_vld & d_sop;
            q_eop  <= d_vld & d_eop;
            q_err  <= d_vld & d_err;
            q_miss <= d_vld & d_miss;
            q_chan <= d_chan;
            q_data <= d_data;
        end
    end
endmodule

// File: rtl/msr_sop_repair.sv
module msr_sop_repair
    import msr_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_err,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [DATA_W-1:0] in_data,
    input  logic              link_err,
    output logic              out_vld,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic [CHAN_W-1:0] out_chan,
    output logic [DATA_W-1:0] out_data,
    output logic              msop_err
);
    ch_state_e cur_state;
    ch_state_e nxt_state;
    logic      fix_sop;
    logic      fix_err;
    logic      miss;

    msr_state_table #(.CHAN_W(CHAN_W)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_chan    (in_chan),
        .rd_state   (cur_state),
        .wr_en      (in_vld),
        .wr_chan    (in_chan),
        .wr_state   (nxt_state),
        .poison_all (link_err)
    );

    msr_decide decide_i (
        .in_vld    (in_vld),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_err    (in_err),
        .link_err  (link_err),
        .cur_state (cur_state),
        .nxt_state (nxt_state),
        .fix_sop   (fix_sop),
        .fix_err   (fix_err),
        .miss      (miss)
    );

    msr_out_stage #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_vld  (in_vld),
        .d_sop  (fix_sop),
        .d_eop  (in_eop),
        .d_err  (fix_err),
        .d_miss (miss),
        .d_chan (in_chan),
        .d_data (in_data),
        .q_vld  (out_vld),
        .q_sop  (out_sop),
        .q_eop  (out_eop),
        .q_err  (out_err),
        .q_miss (msop_err),
        .q_chan (out_chan),
        .q_data (out_data)
    );
endmodule

// File: rtl/msr_sop_repair_chk.sv
module msr_sop_repair_chk #(
    parameter int DATA_W = 64,
    parameter int CHAN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_vld,
    input logic              in_sop,
    input logic              in_eop,
    input logic              in_err,
    input logic [CHAN_W-1:0] in_chan,
    input logic [DATA_W-1:0] in_data,
    input logic              out_vld,
    input logic              out_sop,
    input logic              out_eop,
    input logic              out_err,
    input logic [CHAN_W-1:0] out_chan,
    input logic [DATA_W-1:0] out_data,
    input logic              msop_err
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    a_r1_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (out_vld == $past(in_vld)));

    a_r1_payload_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && out_vld) |-> (out_data == $past(in_data) && out_chan == $past(in_chan)));

    a_r2_miss_needs_nosop: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && msop_err) |-> $past(in_vld && !in_sop));

    a_r3_miss_has_sop: assert property (@(posedge clk) disable iff (!rst_n)
        msop_err |-> (out_vld && out_sop));

    a_r6_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(in_vld && in_sop)) |-> (out_sop && !msop_err));

    a_r6_err_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(in_vld && in_err)) |-> out_err);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (!out_sop && !out_eop && !out_err && !msop_err));
endmodule

bind msr_sop_repair msr_sop_repair_chk #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .in_err   (in_err),
    .in_chan  (in_chan),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_err  (out_err),
    .out_chan (out_chan),
    .out_data (out_data),
    .msop_err (msop_err)
);

// File: tb/msr_sop_repair_tb_top.sv
module msr_sop_repair_tb_top;
    localparam int DATA_W = 64;
    localparam int CHAN_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic              in_sop = 1'b0;
    logic              in_eop = 1'b0;
    logic              in_err = 1'b0;
    logic [CHAN_W-1:0] in_chan = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              link_err = 1'b0;
    logic              out_vld, out_sop, out_eop, out_err, msop_err;
    logic [CHAN_W-1:0] out_chan;
    logic [DATA_W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    msr_sop_repair #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .in_chan(in_chan), .in_data(in_data), .link_err(link_err),
        .out_vld(out_vld), .out_sop(out_sop), .out_eop(out_eop), .out_err(out_err),
        .out_chan(out_chan), .out_data(out_data), .msop_err(msop_err)
    );

    task automatic check(input string req, input logic [DATA_W+CHAN_W+4:0] act,
                         input logic [DATA_W+CHAN_W+4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; return at the next falling edge,
    // where the registered result of that cycle is visible.
    task automatic step(input bit v, input int ch, input bit s, input bit e,
                        input bit er, input bit le, input logic [DATA_W-1:0] d);
        in_vld = v; in_chan = CHAN_W'(ch); in_sop = s; in_eop = e;
        in_err = er; link_err = le; in_data = d;
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0; link_err = 1'b0;
    endtask

    // Expected output of a valid beat: vld, sop, eop, err, msop, chan, data.
    task automatic expect_beat(input string req, input int ch, input bit s, input bit e,
                               input bit er, input bit m, input logic [DATA_W-1:0] d);
        check(req, {out_vld, out_sop, out_eop, out_err, msop_err, out_chan, out_data},
                   {1'b1, s, e, er, m, CHAN_W'(ch), d});
    endtask

    task automatic t_reset;
        check("R9", {out_vld, out_sop, out_eop, out_err, msop_err, out_chan, out_data}, '0);
    endtask

    task automatic t_clean;
        step(1, 5, 1, 0, 0, 0, 64'h5A01); expect_beat("R6", 5, 1, 0, 0, 0, 64'h5A01);
        step(1, 5, 0, 0, 0, 0, 64'h5A02); expect_beat("R1", 5, 0, 0, 0, 0, 64'h5A02);
        step(1, 5, 0, 1, 0, 0, 64'h5A03); expect_beat("R6", 5, 0, 1, 0, 0, 64'h5A03);
        step(1, 6, 1, 0, 0, 0, 64'h6A01); expect_beat("R6", 6, 1, 0, 0, 0, 64'h6A01);
        step(1, 6, 0, 1, 1, 0, 64'h6A02); expect_beat("R6", 6, 0, 1, 1, 0, 64'h6A02);
        step(0, 6, 0, 0, 0, 0, 64'h0);
        check("R1", {out_vld, out_sop, msop_err}, 3'b000);
    endtask

    task automatic t_repair;
        step(1, 9, 0, 0, 0, 0, 64'h9B01); expect_beat("R2 R3", 9, 1, 0, 0, 1, 64'h9B01);
        step(0, 9, 0, 0, 0, 0, 64'h0);
        check("R2", {1'b0, msop_err}, 2'b00);
        step(1, 9, 0, 0, 0, 0, 64'h9B02); expect_beat("R2", 9, 0, 0, 0, 0, 64'h9B02);
        step(1, 9, 0, 1, 0, 0, 64'h9B03); expect_beat("R4", 9, 0, 1, 1, 0, 64'h9B03);
        step(1, 10, 0, 1, 0, 0, 64'hAB01); expect_beat("R4", 10, 1, 1, 1, 1, 64'hAB01);
        step(1, 10, 1, 1, 0, 0, 64'hAB02); expect_beat("R4", 10, 1, 1, 0, 0, 64'hAB02);
    endtask

    task automatic t_single;
        step(1, 11, 1, 1, 0, 0, 64'hB101); expect_beat("R8", 11, 1, 1, 0, 0, 64'hB101);
        step(1, 11, 0, 0, 0, 0, 64'hB102); expect_beat("R8", 11, 1, 0, 0, 1, 64'hB102);
        step(1, 11, 0, 1, 0, 0, 64'hB103); expect_beat("R8", 11, 0, 1, 1, 0, 64'hB103);
    endtask

    task automatic t_link;
        step(1, 20, 1, 0, 0, 0, 64'h2001); expect_beat("R5", 20, 1, 0, 0, 0, 64'h2001);
        step(1, 21, 1, 0, 0, 0, 64'h2101); expect_beat("R5", 21, 1, 0, 0, 0, 64'h2101);
        step(0, 0, 0, 0, 0, 1, 64'h0);
        step(1, 20, 0, 1, 0, 0, 64'h2002); expect_beat("R5", 20, 0, 1, 1, 0, 64'h2002);
        step(1, 22, 1, 0, 0, 0, 64'h2201); expect_beat("R5", 22, 1, 0, 0, 0, 64'h2201);
        step(1, 22, 0, 1, 0, 0, 64'h2202); expect_beat("R5", 22, 0, 1, 0, 0, 64'h2202);
        step(1, 21, 0, 1, 0, 0, 64'h2102); expect_beat("R5", 21, 0, 1, 1, 0, 64'h2102);
    endtask

    task automatic t_restart;
        step(1, 30, 0, 0, 0, 0, 64'h3001); expect_beat("R7", 30, 1, 0, 0, 1, 64'h3001);
        step(1, 30, 1, 0, 0, 0, 64'h3002); expect_beat("R7", 30, 1, 0, 0, 0, 64'h3002);
        step(1, 30, 0, 1, 0, 0, 64'h3003); expect_beat("R7", 30, 0, 1, 0, 0, 64'h3003);
    endtask

    task automatic t_coincide;
        step(1, 40, 1, 0, 0, 0, 64'h4001); expect_beat("R10", 40, 1, 0, 0, 0, 64'h4001);
        step(1, 40, 0, 1, 0, 1, 64'h4002); expect_beat("R10", 40, 0, 1, 1, 0, 64'h4002);
        step(1, 41, 1, 0, 0, 1, 64'h4101); expect_beat("R10", 41, 1, 0, 0, 0, 64'h4101);
        step(1, 41, 0, 1, 0, 0, 64'h4102); expect_beat("R10", 41, 0, 1, 1, 0, 64'h4102);
    endtask

    task automatic t_interleave;
        step(1, 50, 1, 0, 0, 0, 64'h5001); expect_beat("R11", 50, 1, 0, 0, 0, 64'h5001);
        step(1, 51, 0, 0, 0, 0, 64'h5101); expect_beat("R11", 51, 1, 0, 0, 1, 64'h5101);
        step(1, 50, 0, 0, 0, 0, 64'h5002); expect_beat("R11", 50, 0, 0, 0, 0, 64'h5002);
        step(1, 50, 0, 1, 0, 0, 64'h5003); expect_beat("R11", 50, 0, 1, 0, 0, 64'h5003);
        step(1, 51, 0, 1, 0, 0, 64'h5102); expect_beat("R11", 51, 0, 1, 1, 0, 64'h5102);
        step(1, 255, 0, 1, 0, 0, 64'hFF01); expect_beat("R11", 255, 1, 1, 1, 1, 64'hFF01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean();
        t_repair();
        t_single();
        t_link();
        t_restart();
        t_coincide();
        t_interleave();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule